// File: doc/BRIEF.md
# Sequencer Command and Control Register

This block is the command register of an instruction sequencer. Software writes one word to it to start or halt the sequencer, to force a reset of the sequencer state, to request a short or a full calibration, and to enter or leave standby. The same word reads back the live state. A read shows whether the sequencer runs, whether a reset is still in progress, whether each kind of calibration is pending or active, and whether standby is set.

The block owns the instruction pointer. The sequencer reports the end of each instruction with a strobe, and that strobe advances the pointer. A halt takes effect only at an instruction boundary. A calibration requested while the sequencer runs also waits for that boundary. A calibration requested while the sequencer is stopped begins on the write itself. Each calibration is modelled as a busy interval of fixed length. When it ends it sets its own sticky interrupt flag, and fetching resumes at the current pointer.

A written reset and the power-on reset have the same effect. Each one halts the sequencer, zeroes the pointer, pulses a FIFO-clear strobe, cancels calibrations and clears the flags. The reset bit drops by itself after a short hold, and the hold is extended for as long as standby is set.

Top module: `seq_ctrl_reg`

## Requirements
- R1: While `rst` is high and for one cycle after it, `rd_data` reads 0x0002 (bit 1, reset, set). The pointer and the flags are 0, `fifo_clr` is 1 during `rst`, and the outputs `seq_run`, `standby` and `cal_busy` are 0. In the second cycle after `rst` falls, `rd_data` reads 0x0000.
- R2: Writing a word with bit 0 set makes bit 0 read 1 and raises `seq_run` from the next cycle on. Bit 0 reads 1 whenever the sequencer is running.
- R3: Writing bit 0 as 0 while running leaves bit 0 and `seq_run` at 1 until the cycle in which `instr_done` is high; after that edge both read 0. If the halt write and `instr_done` fall in the same cycle, the halt takes effect at that edge.
- R4: Each `instr_done` seen while running and not calibrating advances `instr_ptr` by one, modulo 2^PTR_W. An `instr_done` seen while stopped or calibrating is ignored. A halt followed by a restart keeps the pointer.
- R5: Writing bit 1 as 1 has these effects on the next cycle: bit 0 reads 0, `instr_ptr` is 0, `irq_flags` is 0, `fifo_clr` is 1 for one cycle, and any pending or active calibration is cancelled. Apart from this, the flags are sticky.
- R6: After a reset write, bit 1 reads 1 for exactly RST_HOLD (2) cycles. While standby (bit 4) is 1 the hold count pauses. After standby returns to 0, bit 1 stays 1 for two more cycles.
- R7: While bit 1 reads 1, writes of the start bit and of the calibration bits are ignored, but writes of the standby bit are accepted.
- R8: Writing bit 2 as 1 while stopped starts a short calibration at that edge. `cal_busy` stays high for SHORT_CYC cycles and bit 2 reads 1 during that time. At the end, bit 2 reads 0 and `irq_flags[3]` is set.
- R9: Writing bit 3 as 1 while stopped starts a full calibration. `cal_busy` stays high for FULL_CYC cycles, then bit 3 reads 0 and `irq_flags[4]` is set.
- R10: A calibration requested while running stays pending, with its bit reading 1 and `seq_run` still high, until `instr_done`. It starts at that edge with `seq_run` low. When it ends, `seq_run` returns high with bit 0 still 1.
- R11: If bits 2 and 3 are both requested, only the full calibration runs. The short request is dropped as the full one starts: bit 2 reads 0 and `irq_flags[3]` is never set by it.
- R12: Every accepted write copies its bit 4 into the standby state at that edge. The standby state reads back on bit 4 and drives `standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | DATA_W | Control word to write |
| rd_data | output | DATA_W | Control word read back |
| instr_done | input | 1 | Sequencer finished its current instruction |
| seq_run | output | 1 | Sequencer may fetch and execute |
| instr_ptr | output | PTR_W | Instruction pointer |
| fifo_clr | output | 1 | One-cycle conversion FIFO clear |
| cal_busy | output | 1 | A calibration interval is in progress |
| standby | output | 1 | Standby state |
| irq_flags | output | IRQ_W | Sticky interrupt flags (bit 3 short, bit 4 full) |

## Verification
The coincidences that matter here are between `instr_done` and a register write. The bench provokes each one by driving the write and the strobe in the same cycle. A halt written with the strobe must stop the sequencer at once and still advance the pointer. A pending calibration must start on the same edge that ends the instruction. Strobes pulsed during a calibration must leave the pointer untouched. Each case is judged by reading back the control word and the pointer one cycle after the shared edge and counting the busy cycles that follow.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // control word bit positions (software decodes these)
  localparam int unsigned B_RUN   = 0;
  localparam int unsigned B_RST   = 1;
  localparam int unsigned B_SHORT = 2;
  localparam int unsigned B_FULL  = 3;
  localparam int unsigned B_STBY  = 4;
  // interrupt flag positions
  localparam int unsigned F_SHORT = 3;
  localparam int unsigned F_FULL  = 4;

  typedef enum logic {CAL_SHORT = 1'b0, CAL_FULL = 1'b1} cal_kind_e;
endpackage

// File: rtl/scr_reset_hold.sv
module scr_reset_hold #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic stby_val,
  output logic rst_bit,
  output logic standby
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_bit <= 1'b1;
      cnt     <= LOAD;
      standby <= 1'b0;
    end else begin
      if (wr_en) standby <= stby_val;
      if (wr_rst) begin
        rst_bit <= 1'b1;
        cnt     <= LOAD;
      end else if (rst_bit && !standby) begin
        if (cnt == '0) rst_bit <= 1'b0;
        else           cnt     <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/scr_cal_engine.sv
module scr_cal_engine
  import scr_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 76,
  parameter int unsigned FULL_CYC  = 4944
) (
  input  logic clk,
  input  logic clr,
  input  logic req_short,
  input  logic req_full,
  input  logic allow,
  output logic busy,
  output logic rd_short,
  output logic rd_full,
  output logic fin_short,
  output logic fin_full
);
  localparam int unsigned MAXC = (FULL_CYC > SHORT_CYC) ? FULL_CYC : SHORT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic          pend_s, pend_f;
  logic [CW-1:0] cnt;
  cal_kind_e     kind;
  logic          nxt_s, nxt_f, go, fin;

  assign nxt_s = pend_s | req_short;
  assign nxt_f = pend_f | req_full;
  assign go    = (nxt_s | nxt_f) & ~busy & allow;
  assign fin   = busy & (cnt == '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      pend_s <= 1'b0;
      pend_f <= 1'b0;
      busy   <= 1'b0;
      cnt    <= '0;
      kind   <= CAL_SHORT;
    end else if (busy) begin
      if (fin) busy <= 1'b0;
      else     cnt  <= cnt - CW'(1);
      pend_s <= nxt_s;
      pend_f <= nxt_f;
    end else if (go) begin
      busy   <= 1'b1;
      pend_s <= 1'b0;            // a short request is dropped if full wins
      pend_f <= 1'b0;
      if (nxt_f) begin
        kind <= CAL_FULL;
        cnt  <= CW'(FULL_CYC - 1);
      end else begin
        kind <= CAL_SHORT;
        cnt  <= CW'(SHORT_CYC - 1);
      end
    end else begin
      pend_s <= nxt_s;
      pend_f <= nxt_f;
    end
  end

  assign rd_short  = pend_s | (busy & (kind == CAL_SHORT));
  assign rd_full   = pend_f | (busy & (kind == CAL_FULL));
  assign fin_short = fin & (kind == CAL_SHORT);
  assign fin_full  = fin & (kind == CAL_FULL);
endmodule

// File: rtl/scr_run_ctrl.sv
module scr_run_ctrl #(
  parameter int unsigned PTR_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             wr_go,
  input  logic             wr_halt,
  input  logic             instr_done,
  input  logic             cal_busy,
  output logic             run_bit,
  output logic             seq_run,
  output logic             done_now,
  output logic [PTR_W-1:0] ptr
);
  logic halt_pend;

  assign done_now = instr_done & run_bit & ~cal_busy;
  assign seq_run  = run_bit & ~cal_busy;

  always_ff @(posedge clk) begin
    if (clr) begin
      run_bit   <= 1'b0;
      halt_pend <= 1'b0;
      ptr       <= '0;
    end else begin
      ptr <= ptr + PTR_W'(done_now);
      if (wr_go) begin
        run_bit   <= 1'b1;
        halt_pend <= 1'b0;
      end else if ((wr_halt || halt_pend) && done_now) begin
        run_bit   <= 1'b0;
        halt_pend <= 1'b0;
      end else if (wr_halt && run_bit) begin
        halt_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_ctrl_reg.sv
module seq_ctrl_reg
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PTR_W     = 3,
  parameter int unsigned IRQ_W     = 5,
  parameter int unsigned RST_HOLD  = 2,
  parameter int unsigned SHORT_CYC = 76,
  parameter int unsigned FULL_CYC  = 4944
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              instr_done,
  output logic              seq_run,
  output logic [PTR_W-1:0]  instr_ptr,
  output logic              fifo_clr,
  output logic              cal_busy,
  output logic              standby,
  output logic [IRQ_W-1:0]  irq_flags
);
  logic wr_rst, clr, cmd_ok, rst_bit, run_bit, done_now;
  logic rd_s, rd_f, fin_s, fin_f;
  logic unused_hi;

  assign unused_hi = ^wr_data;
  assign wr_rst = wr_en & wr_data[B_RST];
  assign clr    = rst | wr_rst;
  assign cmd_ok = wr_en & ~wr_rst & ~rst_bit;

  scr_reset_hold #(.HOLD(RST_HOLD)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_rst   (wr_rst),
    .stby_val (wr_data[B_STBY]),
    .rst_bit  (rst_bit),
    .standby  (standby)
  );

  scr_run_ctrl #(.PTR_W(PTR_W)) u_run (
    .clk        (clk),
    .clr        (clr),
    .wr_go      (cmd_ok & wr_data[B_RUN]),
    .wr_halt    (cmd_ok & ~wr_data[B_RUN]),
    .instr_done (instr_done),
    .cal_busy   (cal_busy),
    .run_bit    (run_bit),
    .seq_run    (seq_run),
    .done_now   (done_now),
    .ptr        (instr_ptr)
  );

  scr_cal_engine #(.SHORT_CYC(SHORT_CYC), .FULL_CYC(FULL_CYC)) u_cal (
    .clk       (clk),
    .clr       (clr),
    .req_short (cmd_ok & wr_data[B_SHORT]),
    .req_full  (cmd_ok & wr_data[B_FULL]),
    .allow     (~run_bit | done_now),
    .busy      (cal_busy),
    .rd_short  (rd_s),
    .rd_full   (rd_f),
    .fin_short (fin_s),
    .fin_full  (fin_f)
  );

  always_ff @(posedge clk) begin
    fifo_clr <= clr;
    if (clr) begin
      irq_flags <= '0;
    end else begin
      if (fin_s) irq_flags[F_SHORT] <= 1'b1;
      if (fin_f) irq_flags[F_FULL]  <= 1'b1;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_RUN]   = run_bit;
    rd_data[B_RST]   = rst_bit;
    rd_data[B_SHORT] = rd_s;
    rd_data[B_FULL]  = rd_f;
    rd_data[B_STBY]  = standby;
  end
endmodule

// File: rtl/seq_ctrl_reg_chk.sv
module seq_ctrl_reg_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned IRQ_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              instr_done,
  input logic              seq_run,
  input logic [PTR_W-1:0]  instr_ptr,
  input logic              fifo_clr,
  input logic              cal_busy,
  input logic              standby,
  input logic [IRQ_W-1:0]  irq_flags
);
  p_halt_waits_r3: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] && !instr_done && !(wr_en && wr_data[1]) |=> rd_data[0]);

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !instr_done && !(wr_en && wr_data[1]) |=> $stable(instr_ptr));

  p_reset_effects_r5: assert property (@(posedge clk) disable iff (rst)
    wr_en && wr_data[1] |=> fifo_clr && instr_ptr == '0 && irq_flags == '0
                           && !rd_data[0] && !cal_busy);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    irq_flags[4] && !(wr_en && wr_data[1]) |=> irq_flags[4]);

  p_rst_bit_min_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[1]) |=> rd_data[1]);

  p_cal_at_boundary_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_busy) && $past(seq_run) |-> $past(instr_done));

  p_standby_now_r12: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> standby == $past(wr_data[4]));
endmodule

bind seq_ctrl_reg seq_ctrl_reg_chk #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .IRQ_W(IRQ_W)
) u_chk (.*);

// File: tb/tb_seq_ctrl_reg.sv
module tb_seq_ctrl_reg;
  localparam int CLK_P  = 10;
  localparam int DW     = 16;
  localparam int PW     = 3;
  localparam int IW     = 5;
  localparam int SHORTC = 7;
  localparam int FULLC  = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          instr_done = 1'b0;
  logic          seq_run, fifo_clr, cal_busy, standby;
  logic [PW-1:0] instr_ptr;
  logic [IW-1:0] irq_flags;

  int checks = 0;
  int errors = 0;
  int eptr   = 0;

  always #(CLK_P/2) clk = ~clk;

  seq_ctrl_reg #(.DATA_W(DW), .PTR_W(PW), .IRQ_W(IW), .RST_HOLD(2),
                 .SHORT_CYC(SHORTC), .FULL_CYC(FULLC)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .instr_done(instr_done), .seq_run(seq_run), .instr_ptr(instr_ptr),
    .fifo_clr(fifo_clr), .cal_busy(cal_busy), .standby(standby),
    .irq_flags(irq_flags));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input int v);
    wr_en = 1'b1; wr_data = DW'(v);
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_done();
    instr_done = 1'b1;
    tick();
    instr_done = 1'b0;
  endtask

  // counts busy cycles, the current cycle included when busy
  task automatic count_busy(input int start, output int n);
    n = start;
    for (int k = 0; k < 100 && cal_busy; k++) begin
      tick();
      if (cal_busy) n++;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    tick(); tick(); tick();
    // R1 reset state
    chk("R1 rd", int'(rd_data), 'h2);
    chk("R1 ptr", int'(instr_ptr), 0);
    chk("R1 irq", int'(irq_flags), 0);
    chk("R1 fifo_clr", int'(fifo_clr), 1);
    chk("R1 outs", int'({seq_run, standby, cal_busy}), 0);
    rst = 1'b0;
    tick(); chk("R1 hold", int'(rd_data), 'h2);
    tick(); chk("R1 released", int'(rd_data), 'h0);
    chk("R1 fifo_clr low", int'(fifo_clr), 0);

    // R12 standby
    wr('h10); chk("R12 rd", int'(rd_data), 'h10); chk("R12 pin", int'(standby), 1);
    wr('h00); chk("R12 clear", int'(rd_data), 'h0); chk("R12 pin0", int'(standby), 0);

    // R2 start
    wr('h1); chk("R2 rd0", int'(rd_data[0]), 1); chk("R2 seq_run", int'(seq_run), 1);

    // R4 pointer sweep with wrap
    for (int i = 1; i <= 20; i++) begin
      pulse_done(); eptr = i % (1 << PW);
      chk("R4 ptr", int'(instr_ptr), eptr);
    end

    // R3 deferred halt
    wr('h0);
    chk("R3 still run", int'(rd_data[0]), 1); chk("R3 seq_run", int'(seq_run), 1);
    for (int i = 0; i < 3; i++) begin tick(); chk("R3 wait", int'(rd_data[0]), 1); end
    pulse_done(); eptr = (eptr + 1) % (1 << PW);
    chk("R3 halted", int'(rd_data[0]), 0); chk("R3 seq_run0", int'(seq_run), 0);
    chk("R4 last", int'(instr_ptr), eptr);
    pulse_done(); chk("R4 stopped ignore", int'(instr_ptr), eptr);
    wr('h1); chk("R4 resume ptr", int'(instr_ptr), eptr); chk("R2 rerun", int'(seq_run), 1);
    // R3 halt and done in the same cycle
    instr_done = 1'b1; wr('h0); instr_done = 1'b0; eptr = (eptr + 1) % (1 << PW);
    chk("R3 same-cycle halt", int'(rd_data[0]), 0);
    chk("R3 same-cycle ptr", int'(instr_ptr), eptr);

    // R8 short while stopped
    wr('h4);
    chk("R8 busy", int'(cal_busy), 1); chk("R8 rd2", int'(rd_data[2]), 1);
    pulse_done(); chk("R8 done ignored", int'(instr_ptr), eptr);
    count_busy(2, n); chk("R8 length", n, SHORTC);
    chk("R8 rd2 clear", int'(rd_data[2]), 0);
    chk("R8 flags", int'(irq_flags), 'h08);

    // R9 full while stopped
    wr('h8); chk("R9 rd3", int'(rd_data[3]), 1);
    count_busy(1, n); chk("R9 length", n, FULLC);
    chk("R9 rd3 clear", int'(rd_data[3]), 0);
    chk("R9 flags sticky", int'(irq_flags), 'h18);

    // R5 written reset cancels a pending calibration
    wr('h1); pulse_done(); wr('h5);
    chk("R10 pending", int'(rd_data[2]), 1);
    wr('h2);
    chk("R5 rd", int'(rd_data), 'h2); chk("R5 ptr", int'(instr_ptr), 0);
    chk("R5 irq", int'(irq_flags), 0); chk("R5 fifo_clr", int'(fifo_clr), 1);
    chk("R5 cal", int'(cal_busy), 0);
    tick(); chk("R5 fifo pulse", int'(fifo_clr), 0);
    tick(); chk("R6 two cycles", int'(rd_data), 'h0);

    // R7 commands ignored while reset bit is set
    wr('h2); wr('h5);
    chk("R7 ignored", int'(rd_data), 'h2); chk("R7 no cal", int'(cal_busy), 0);
    tick(); chk("R7 after", int'(rd_data), 'h0);

    // R6 standby extends reset hold
    wr('h12); chk("R6 held", int'(rd_data), 'h12);
    for (int i = 0; i < 4; i++) begin tick(); chk("R6 held long", int'(rd_data), 'h12); end
    wr('h00); chk("R6 release 1", int'(rd_data), 'h2);
    tick(); chk("R6 release 2", int'(rd_data), 'h2);
    tick(); chk("R6 release 3", int'(rd_data), 'h0);

    // R10 deferral while running
    wr('h1); pulse_done(); eptr = 1;
    wr('h5);
    chk("R10 wait rd2", int'(rd_data[2]), 1); chk("R10 wait busy", int'(cal_busy), 0);
    chk("R10 wait run", int'(seq_run), 1);
    tick(); tick(); chk("R10 still waiting", int'(cal_busy), 0);
    pulse_done(); eptr = 2;
    chk("R10 start", int'(cal_busy), 1); chk("R10 no fetch", int'(seq_run), 0);
    chk("R10 ptr", int'(instr_ptr), eptr);
    pulse_done(); chk("R10 done ignored", int'(instr_ptr), eptr);
    count_busy(2, n); chk("R10 length", n, SHORTC);
    chk("R10 resume", int'(seq_run), 1); chk("R10 rd0", int'(rd_data[0]), 1);
    chk("R10 flag", int'(irq_flags[3]), 1);

    // R11 both requested: full wins, short dropped
    wr('h2); tick(); tick();
    wr('hC);
    chk("R11 rd", int'(rd_data[3:2]), 'b10);
    count_busy(1, n); chk("R11 length", n, FULLC);
    for (int i = 0; i < 3; i++) tick();
    chk("R11 no short", int'(cal_busy), 0);
    chk("R11 flags", int'(irq_flags), 'h10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule